// File: doc/BRIEF.md
# Evenly Spaced Stochastic Lookup Table

This block is a small lookup table whose select inputs are independent pseudo-random bit streams rather than fixed logic levels. Select stream k (counting from 1) is high with probability 2^(2^(k−1)) / (2^(2^(k−1)) + 1): 2/3 and 4/5 with two inputs, and 16/17 for a third input. Table row i then occurs with probability 2^i / (2^R − 1), where R = 2^NUM_IN is the number of rows. A table word `cfg` therefore reads directly as a binary numerator. The output bit stream is high with probability cfg / (2^R − 1), and the 2^R possible table words cover the unit interval in equal steps.

Each select stream comes from its own linear-feedback shift register. The register advances a full register width per enabled cycle, and its state is compared with a rounded threshold. The table output is registered. A rate monitor counts the ones in fixed windows of enabled samples and reports whether the count lies close to the value the table word predicts. A combinational quantizer turns a fixed-point target probability into the nearest table word.

Top module: `stoch_lut_gen`

## Requirements
- R1: Select stream k is high when its LFSR_W-bit shift-register state, read as an unsigned number, is below round(p_k · 2^LFSR_W), with p_k = 2^(2^(k−1)) / (2^(2^(k−1)) + 1). With two inputs, table word 4'b1010 therefore yields a rate of 2/3 and 4'b1100 yields 4/5.
- R2: The row index is formed with stream NUM_IN as its most significant bit and stream 1 as its least significant bit. Row i emits bit i of `cfg`, so the measured rate of ones is cfg / (2^R − 1).
- R3: With `cfg` all zeros the output is 0 on every enabled cycle. With `cfg` all ones it is 1 on every enabled cycle.
- R4: `stoch_out` is registered: it shows the table bit one clock after the sample is taken. Any cycle that follows a cycle with `en` low shows 0.
- R5: After synchronous reset, `stoch_out`, `win_done`, `win_pass` and `win_ones` are all 0.
- R6: The monitor counts ones over 2^WIN_LOG consecutive valid output samples. It then raises `win_done` for exactly one cycle and presents the total on `win_ones`. With no interruption, `win_done` appears 2^WIN_LOG + 1 clock edges after the edge that first samples a new setting.
- R7: `win_pass` is 1 when the window total differs from round(cfg · 2^WIN_LOG / (2^R − 1)) by at most floor(2^WIN_LOG · TOL_PCT / 100).
- R8: A change of `cfg`, or a cycle with `en` low, discards the window in progress. A fresh window starts with the next valid sample.
- R9: `tgt_cfg` equals floor((tgt_q · (2^R − 1) + 2^(Q_W−1)) / 2^Q_W), which rounds ties upward. For example, tgt_q = 0x8000 gives 8 with two inputs.
- R10: The row patterns z0..z3 = 1,0,1,0 and 1,0,1,1 correspond to cfg = 5 and cfg = 13. With two inputs they give rates of 5/15 and 13/15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance the sources and emit samples |
| cfg | input | 2^NUM_IN | Table word; bit i is the output of row i |
| tgt_q | input | Q_W | Target probability as an unsigned fraction of 2^Q_W |
| tgt_cfg | output | 2^NUM_IN | Nearest table word for `tgt_q` |
| stoch_out | output | 1 | Registered stochastic output bit |
| win_done | output | 1 | One-cycle pulse at the end of a monitor window |
| win_pass | output | 1 | Last window's count lay within tolerance |
| win_ones | output | WIN_LOG+1 | Ones counted in the last completed window |

## Verification
The bench builds the block with two select inputs, 4096-sample windows, a 5 % tolerance and a 16-bit target. At that size every one of the sixteen table words gets a full window, which is small enough to sweep completely. The bench keeps its own count of output ones in each window and compares it exactly with the monitor total and approximately with cfg·4096/15. Adjacent words differ by about 273 counts, while the tolerance is 204, so a wrong row order or wrong threshold shows up. The quantizer is swept across its whole input range in strides and also at its tie point.

// File: rtl/stoch_lut_pkg.sv
package stoch_lut_pkg;

    // A registered output sample together with its validity.
    typedef struct packed {
        logic vld;
        logic val;
    } smp_t;

    // Comparison threshold for select stream k (zero based):
    // round(a/(a+1) * 2^w) with a = 2^(2^k).
    function automatic longint unsigned src_thresh(int unsigned k, int unsigned w);
        longint unsigned a;
        longint unsigned den;
        a   = 64'd1 << (64'd1 << k);
        den = a + 64'd1;
        return ((a << w) + den / 64'd2) / den;
    endfunction

    // Distinct non-zero start state for each stream.
    function automatic longint unsigned src_seed(int unsigned k, int unsigned w);
        longint unsigned v;
        longint unsigned mask;
        v    = 64'h5A5A_1234 ^ (64'(k + 1) * 64'h9E37_79B9);
        mask = (64'd1 << w) - 64'd1;
        v    = v & mask;
        if (v == 64'd0)
            v = 64'd1;
        return v;
    endfunction

    // Integer division rounded to nearest, ties upward.
    function automatic longint unsigned div_round(longint unsigned num, longint unsigned den);
        return (num + den / 64'd2) / den;
    endfunction

endpackage

// File: rtl/stoch_bit_src.sv
module stoch_bit_src #(
    parameter int unsigned          LFSR_W = 24,
    parameter logic [LFSR_W-1:0]    TAPS   = 24'hE10000,
    parameter longint unsigned      SEED   = 1,
    parameter longint unsigned      THRESH = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output logic bit_o
);
    localparam logic [LFSR_W:0]   THR   = (LFSR_W + 1)'(THRESH);
    localparam logic [LFSR_W-1:0] START = LFSR_W'(SEED);

    logic [LFSR_W-1:0] st;
    logic [LFSR_W-1:0] nxt;

    // Advance a full register width so successive draws share no bits.
    always_comb begin
        nxt = st;
        for (int i = 0; i < int'(LFSR_W); i++) begin
            nxt = {nxt[LFSR_W-2:0], ^(nxt & TAPS)};
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            st <= START;
        else if (adv)
            st <= nxt;
    end

    assign bit_o = ({1'b0, st} < THR);

endmodule

// File: rtl/stoch_lut_core.sv
module stoch_lut_core
    import stoch_lut_pkg::*;
#(
    parameter int unsigned NUM_IN = 2,
    localparam int unsigned ROWS  = 1 << NUM_IN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [NUM_IN-1:0] sel,
    input  logic [ROWS-1:0]   cfg,
    output smp_t              smp,
    output logic [ROWS-1:0]   smp_cfg
);
    smp_t smp_r;
    logic [ROWS-1:0] cfg_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_r <= '0;
            cfg_r <= '0;
        end else begin
            smp_r.vld <= en;
            smp_r.val <= en ? cfg[sel] : 1'b0;
            cfg_r     <= cfg;
        end
    end

    assign smp     = smp_r;
    assign smp_cfg = cfg_r;

endmodule

// File: rtl/stoch_rate_monitor.sv
module stoch_rate_monitor
    import stoch_lut_pkg::*;
#(
    parameter int unsigned ROWS    = 4,
    parameter int unsigned WIN_LOG = 18,
    parameter int unsigned TOL_PCT = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  smp_t             smp,
    input  logic [ROWS-1:0]  smp_cfg,
    output logic             done,
    output logic             pass,
    output logic [WIN_LOG:0] ones
);
    localparam longint unsigned WIN_N = 64'd1 << WIN_LOG;
    localparam longint unsigned DEN   = (64'd1 << ROWS) - 64'd1;
    localparam longint unsigned TOL   = (WIN_N * 64'(TOL_PCT)) / 64'd100;

    logic [WIN_LOG-1:0] cnt;
    logic [WIN_LOG:0]   acc;
    logic [WIN_LOG:0]   tot;
    logic [ROWS-1:0]    last_cfg;
    logic               near;

    assign tot = acc + {{WIN_LOG{1'b0}}, smp.val};

    always_comb begin
        longint unsigned exp_v;
        longint unsigned got_v;
        longint unsigned diff;
        exp_v = div_round(64'(smp_cfg) * WIN_N, DEN);
        got_v = 64'(tot);
        diff  = (got_v > exp_v) ? (got_v - exp_v) : (exp_v - got_v);
        near  = (diff <= TOL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            acc      <= '0;
            last_cfg <= '0;
            done     <= 1'b0;
            pass     <= 1'b0;
            ones     <= '0;
        end else begin
            done     <= 1'b0;
            last_cfg <= smp_cfg;
            if (!smp.vld) begin
                cnt <= '0;
                acc <= '0;
            end else if (smp_cfg != last_cfg) begin
                cnt <= WIN_LOG'(1);
                acc <= {{WIN_LOG{1'b0}}, smp.val};
            end else if (cnt == {WIN_LOG{1'b1}}) begin
                cnt  <= '0;
                acc  <= '0;
                done <= 1'b1;
                ones <= tot;
                pass <= near;
            end else begin
                cnt <= cnt + WIN_LOG'(1);
                acc <= tot;
            end
        end
    end

endmodule

// File: rtl/stoch_quantizer.sv
module stoch_quantizer #(
    parameter int unsigned ROWS = 4,
    parameter int unsigned Q_W  = 16
) (
    input  logic [Q_W-1:0]  tgt_q,
    output logic [ROWS-1:0] tgt_cfg
);
    localparam int unsigned PW = Q_W + ROWS;
    localparam logic [PW-1:0] DEN  = PW'((64'd1 << ROWS) - 64'd1);
    localparam logic [PW-1:0] HALF = PW'(64'd1 << (Q_W - 1));

    logic [PW-1:0] prod;
    logic [PW-1:0] sum;

    assign prod    = {{ROWS{1'b0}}, tgt_q} * DEN;
    assign sum     = prod + HALF;
    assign tgt_cfg = sum[PW-1:Q_W];

endmodule

// File: rtl/stoch_lut_gen.sv
module stoch_lut_gen
    import stoch_lut_pkg::*;
#(
    parameter int unsigned       NUM_IN    = 2,
    parameter int unsigned       LFSR_W    = 24,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 24'hE10000,
    parameter int unsigned       WIN_LOG   = 18,
    parameter int unsigned       TOL_PCT   = 1,
    parameter int unsigned       Q_W       = 16,
    localparam int unsigned      ROWS      = 1 << NUM_IN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [ROWS-1:0]  cfg,
    input  logic [Q_W-1:0]   tgt_q,
    output logic [ROWS-1:0]  tgt_cfg,
    output logic             stoch_out,
    output logic             win_done,
    output logic             win_pass,
    output logic [WIN_LOG:0] win_ones
);
    logic [NUM_IN-1:0] sel;
    smp_t              smp;
    logic [ROWS-1:0]   smp_cfg;

    // One independent source per select input; bit k-1 carries input k.
    for (genvar k = 0; k < int'(NUM_IN); k++) begin : g_src
        localparam longint unsigned THR_K  = src_thresh(k, LFSR_W);
        localparam longint unsigned SEED_K = src_seed(k, LFSR_W);
        stoch_bit_src #(
            .LFSR_W (LFSR_W),
            .TAPS   (LFSR_TAPS),
            .SEED   (SEED_K),
            .THRESH (THR_K)
        ) u_src (
            .clk   (clk),
            .rst   (rst),
            .adv   (en),
            .bit_o (sel[k])
        );
    end

    stoch_lut_core #(.NUM_IN(NUM_IN)) u_core (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .sel     (sel),
        .cfg     (cfg),
        .smp     (smp),
        .smp_cfg (smp_cfg)
    );

    stoch_rate_monitor #(
        .ROWS    (ROWS),
        .WIN_LOG (WIN_LOG),
        .TOL_PCT (TOL_PCT)
    ) u_mon (
        .clk     (clk),
        .rst     (rst),
        .smp     (smp),
        .smp_cfg (smp_cfg),
        .done    (win_done),
        .pass    (win_pass),
        .ones    (win_ones)
    );

    stoch_quantizer #(.ROWS(ROWS), .Q_W(Q_W)) u_quant (
        .tgt_q   (tgt_q),
        .tgt_cfg (tgt_cfg)
    );

    assign stoch_out = smp.val;

endmodule

// File: rtl/stoch_lut_gen_chk.sv
module stoch_lut_gen_chk #(
    parameter int unsigned ROWS = 4,
    parameter int unsigned Q_W  = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            en,
    input logic [ROWS-1:0] cfg,
    input logic [Q_W-1:0]  tgt_q,
    input logic [ROWS-1:0] tgt_cfg,
    input logic            stoch_out,
    input logic            win_done
);
    // R4
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$past(en)) |-> !stoch_out);

    // R3
    zero_table_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && ($past(cfg) == '0)) |-> !stoch_out);

    // R3
    full_table_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(en) && ($past(cfg) == '1)) |-> stoch_out);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        win_done |=> !win_done);

    // R5
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!win_done && !stoch_out));

    // R9
    quant_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (tgt_q == '0) |-> (tgt_cfg == '0));

endmodule

bind stoch_lut_gen stoch_lut_gen_chk #(.ROWS(ROWS), .Q_W(Q_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .cfg       (cfg),
    .tgt_q     (tgt_q),
    .tgt_cfg   (tgt_cfg),
    .stoch_out (stoch_out),
    .win_done  (win_done)
);

// File: tb/stoch_lut_gen_test.sv
module stoch_lut_gen_test;
    localparam int NUM_IN  = 2;
    localparam int ROWS    = 4;
    localparam int WIN_LOG = 12;
    localparam int TOL_PCT = 5;
    localparam int Q_W     = 16;
    localparam int WIN_N   = 1 << WIN_LOG;
    localparam int DEN     = 15;
    localparam int TOL     = (WIN_N * TOL_PCT) / 100;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             en  = 1'b0;
    logic [ROWS-1:0]  cfg = '0;
    logic [Q_W-1:0]   tgt_q = '0;
    logic [ROWS-1:0]  tgt_cfg;
    logic             stoch_out;
    logic             win_done;
    logic             win_pass;
    logic [WIN_LOG:0] win_ones;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    always #2.5 clk = ~clk;

    stoch_lut_gen #(
        .NUM_IN  (NUM_IN),
        .WIN_LOG (WIN_LOG),
        .TOL_PCT (TOL_PCT),
        .Q_W     (Q_W)
    ) uut (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .cfg       (cfg),
        .tgt_q     (tgt_q),
        .tgt_cfg   (tgt_cfg),
        .stoch_out (stoch_out),
        .win_done  (win_done),
        .win_pass  (win_pass),
        .win_ones  (win_ones)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    // Runs one full window with the current cfg/en, which were set at a negedge.
    task automatic run_window(input int c, input string req);
        int ones;
        int early;
        int expv;
        int diff;
        bit const_ok;
        ones = 0;
        early = 0;
        const_ok = 1'b1;
        for (int j = 0; j < WIN_N; j++) begin
            @(posedge clk);
            @(negedge clk);
            if (stoch_out) ones++;
            if (win_done) early++;
            if (c == 0 && stoch_out) const_ok = 1'b0;
            if (c == 15 && !stoch_out) const_ok = 1'b0;
        end
        check(early == 0, "R8 no early window end", early, 0);
        @(posedge clk);
        @(negedge clk);
        check(win_done == 1'b1, "R6 window end pulse", int'(win_done), 1);
        check(int'(win_ones) == ones, "R6 monitor total", int'(win_ones), ones);
        expv = (c * WIN_N + DEN / 2) / DEN;
        diff = (ones > expv) ? ones - expv : expv - ones;
        check(diff <= TOL, req, ones, expv);
        check(win_pass == 1'b1, "R7 pass flag", int'(win_pass), 1);
        if (c == 0 || c == 15)
            check(const_ok, "R3 constant output", int'(const_ok), 1);
    endtask

    initial begin
        #(5.0 * 190000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R5 reset state
        check(stoch_out == 1'b0, "R5 out", int'(stoch_out), 0);
        check(win_done == 1'b0, "R5 done", int'(win_done), 0);
        check(win_pass == 1'b0, "R5 pass", int'(win_pass), 0);
        check(win_ones == '0, "R5 ones", int'(win_ones), 0);
        rst = 1'b0;

        // R4: disabled with an all-ones table still emits zeros
        cfg = '1;
        en  = 1'b0;
        for (int j = 0; j < 20; j++) begin
            @(posedge clk);
            @(negedge clk);
            check(stoch_out == 1'b0, "R4 idle output", int'(stoch_out), 0);
            check(win_done == 1'b0, "R8 idle no window", int'(win_done), 0);
        end

        // Sweep all sixteen table words
        for (int c = 0; c < 16; c++) begin
            cfg = ROWS'(c);
            en  = 1'b1;
            if (c == 10 || c == 12)
                run_window(c, "R1 stream rate");
            else if (c == 5 || c == 13)
                run_window(c, "R10 example rate");
            else
                run_window(c, "R2 table rate");
        end

        // R8: change cfg in mid-window, the window restarts
        cfg = 4'd5;
        repeat (1000) @(posedge clk);
        @(negedge clk);
        cfg = 4'd9;
        run_window(9, "R8 restart after cfg change");

        // R8/R4: drop enable in mid-window
        repeat (500) @(posedge clk);
        @(negedge clk);
        en = 1'b0;
        for (int j = 0; j < 3; j++) begin
            @(posedge clk);
            @(negedge clk);
            check(stoch_out == 1'b0, "R4 output after enable drop", int'(stoch_out), 0);
        end
        en = 1'b1;
        run_window(9, "R8 restart after enable drop");

        // R9 quantizer sweep
        for (int t = 0; t < 65536; t += 73) begin
            tgt_q = Q_W'(t);
            #1;
            check(int'(tgt_cfg) == ((t * DEN + 32768) >>> 16), "R9 quantizer", int'(tgt_cfg),
                  (t * DEN + 32768) >>> 16);
        end
        tgt_q = 16'hFFFF;
        #1;
        check(tgt_cfg == 4'd15, "R9 top end", int'(tgt_cfg), 15);
        tgt_q = 16'h8000;
        #1;
        check(tgt_cfg == 4'd8, "R9 tie rounds up", int'(tgt_cfg), 8);
        tgt_q = 16'd2184;
        #1;
        check(tgt_cfg == 4'd0, "R9 below half step", int'(tgt_cfg), 0);
        tgt_q = 16'd2185;
        #1;
        check(tgt_cfg == 4'd1, "R9 at half step", int'(tgt_cfg), 1);

        finish_run();
    end

endmodule